// File: doc/BRIEF.md
# Block transfer sequencer

This block runs one multi-register transfer instruction for a 32-bit core that has sixteen general registers. On a start strobe it captures the instruction word, the addressing mode, the load/store select, the writeback enable, the user-bank flag and the current base register value. It then moves one word per selected register. Each word goes through a single-outstanding memory request/acknowledge port. A load writes the fetched word into the register file. A store reads the register and sends its value to memory.

The register list is walked upward for increment modes and downward for decrement modes. In both cases the lowest-numbered register ends up at the lowest address. After the last word, the block drops its request for the privileged register bank. In the final cycle it writes the adjusted base back if writeback is enabled, flags a program-counter reload when a load included the top register, and pulses done. Memory, the register file, fetch, condition checks and exceptions belong to the surrounding core.

Top module: `blkxfer_seq`

## Requirements
- R1: The register list is taken from instr[15:0], with bit k selecting register k. The base register index is taken from instr[19:16], and writeback targets that register.
- R2: The mode input is encoded as bit 0 = 1 for increment and bit 1 = 1 for the before variant. The first transfer address depends on the mode: 2'b01 (inc-after) and 2'b00 (dec-after) start at the base, 2'b11 (inc-before) starts at base+4, and 2'b10 (dec-before) starts at base-4.
- R3: Increment modes visit the selected registers in ascending order, decrement modes in descending order. Each transfer address differs from the previous one by +4 or -4 respectively. The number of transfers equals the number of set list bits.
- R4: mem_req stays high with a stable address until mem_ack is seen. The block advances only on an acknowledged cycle, and at most one transfer is outstanding. mem_req is low outside a sequence.
- R5: On a load, the acknowledged mem_rdata is written into the selected register. On a store, the selected register's value is driven on mem_wdata with mem_we high.
- R6: With writeback enabled, the base register receives base+4n for increment modes or base-4n for decrement modes, where n is the number of selected registers. This write happens in the done cycle, after every transfer, so it overrides a value loaded into the base. With writeback disabled the base register is not written.
- R7: In the user-bank variant, sys_bank is high on every transfer cycle and is low again in the done cycle.
- R8: pc_reload pulses in the done cycle only for a load whose list has bit 15 set.
- R9: An empty list makes no memory request, still ends with done, and leaves the base register unchanged.
- R10: Bits 1:0 of every issued memory address are zero.
- R11: A start strobe while busy is high is ignored and does not alter the sequence in progress.
- R12: done is high for exactly one cycle per accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, accepted only when idle |
| instr | input | 32 | Instruction word carrying base index and register list |
| mode | input | 2 | Addressing mode: bit0 increment, bit1 before |
| is_load | input | 1 | 1 = load from memory, 0 = store to memory |
| wback_en | input | 1 | Write the adjusted base back at the end |
| user_bank | input | 1 | Request the privileged register bank during the transfers |
| base_val | input | 32 | Current value of the base register |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sys_bank | output | 1 | Privileged-bank request, high during transfers |
| pc_reload | output | 1 | Program counter was loaded; refill the pipeline |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory write (store) |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Store data |
| mem_ack | input | 1 | Memory acknowledge for the current request |
| mem_rdata | input | 32 | Load data, valid with mem_ack |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |

## Verification
The bench builds the block with its default parameters: 32-bit words, sixteen registers and the base index field at bit 16. With these values the top register doubles as the program counter, so the reload flag, the full ascending and descending scans, and a base register that also sits in its own list can all be exercised. The memory model inserts zero to three wait cycles per word. This covers the handshake hold, and it keeps a sequence busy long enough for a second start strobe to land inside it.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

  typedef enum logic [1:0] {
    AM_DA = 2'b00,
    AM_IA = 2'b01,
    AM_DB = 2'b10,
    AM_IB = 2'b11
  } amode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_MOVE = 2'd1,
    SQ_FIN  = 2'd2
  } seq_st_e;

  function automatic logic am_up(input logic [1:0] m);
    return m[0];
  endfunction

  function automatic logic am_before(input logic [1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/blkxfer_pick.sv
// Selects the next pending register: lowest set bit when walking up,
// highest set bit when walking down.
module blkxfer_pick #(
  parameter int NREG = 16,
  parameter int IDXW = $clog2(NREG)
) (
  input  logic [NREG-1:0] pend,
  input  logic            up,
  output logic            any,
  output logic [IDXW-1:0] idx
);
  always_comb begin
    any = |pend;
    idx = '0;
    if (up) begin
      for (int i = NREG - 1; i >= 0; i--) begin
        if (pend[i]) idx = IDXW'(i);
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (pend[i]) idx = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/blkxfer_addr.sv
// Address arithmetic: first address, per-step update, writeback value
// and word alignment of the issued address.
module blkxfer_addr
  import blkxfer_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input  logic [1:0]      start_mode,
  input  logic [XLEN-1:0] base,
  input  logic [1:0]      run_mode,
  input  logic [XLEN-1:0] run_addr,
  output logic [XLEN-1:0] start_addr,
  output logic [XLEN-1:0] next_addr,
  output logic [XLEN-1:0] wb_addr,
  output logic [XLEN-1:0] issue_addr
);
  localparam logic [XLEN-1:0] STEPV = XLEN'(STEP);
  localparam logic [XLEN-1:0] ALIGN_MASK = ~(STEPV - XLEN'(1));

  function automatic logic [XLEN-1:0] f_start(input logic [XLEN-1:0] b,
                                              input logic [1:0] m);
    if (!am_before(m)) return b;
    return am_up(m) ? b + STEPV : b - STEPV;
  endfunction

  function automatic logic [XLEN-1:0] f_next(input logic [XLEN-1:0] a,
                                             input logic [1:0] m);
    return am_up(m) ? a + STEPV : a - STEPV;
  endfunction

  // Undo the pre-offset of the before-modes on the final running address.
  function automatic logic [XLEN-1:0] f_wb(input logic [XLEN-1:0] a,
                                           input logic [1:0] m);
    if (!am_before(m)) return a;
    return am_up(m) ? a - STEPV : a + STEPV;
  endfunction

  function automatic logic [XLEN-1:0] f_align(input logic [XLEN-1:0] a);
    return a & ALIGN_MASK;
  endfunction

  assign start_addr = f_start(base, start_mode);
  assign next_addr  = f_next(run_addr, run_mode);
  assign wb_addr    = f_wb(run_addr, run_mode);
  assign issue_addr = f_align(run_addr);
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NREG     = 16,
  parameter int BASE_LSB = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [XLEN-1:0]          instr,
  input  logic [1:0]               mode,
  input  logic                     is_load,
  input  logic                     wback_en,
  input  logic                     user_bank,
  input  logic [XLEN-1:0]          base_val,
  output logic                     busy,
  output logic                     done,
  output logic                     sys_bank,
  output logic                     pc_reload,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [XLEN-1:0]          mem_addr,
  output logic [XLEN-1:0]          mem_wdata,
  input  logic                     mem_ack,
  input  logic [XLEN-1:0]          mem_rdata,
  output logic [$clog2(NREG)-1:0]  rf_raddr,
  input  logic [XLEN-1:0]          rf_rdata,
  output logic                     rf_we,
  output logic [$clog2(NREG)-1:0]  rf_waddr,
  output logic [XLEN-1:0]          rf_wdata
);
  localparam int IDXW = $clog2(NREG);

  seq_st_e         st_q;
  logic [NREG-1:0] pend_q;
  logic [XLEN-1:0] run_q;
  logic [IDXW-1:0] bidx_q;
  logic [1:0]      mode_q;
  logic            load_q, wb_q, user_q, pcl_q, bank_q;

  // Named internal events
  logic            accept, in_move, in_fin, move_end, xfer_fire;
  logic [NREG-1:0] list_in;
  logic [IDXW-1:0] bidx_in;
  logic            sel_any;
  logic [IDXW-1:0] sel_idx;
  logic [XLEN-1:0] start_addr, next_addr, wb_addr, issue_addr;
  logic            unused_instr_hi;

  assign list_in         = instr[NREG-1:0];
  assign bidx_in         = instr[BASE_LSB +: IDXW];
  assign unused_instr_hi = ^instr[XLEN-1:BASE_LSB+IDXW];

  assign accept   = start && (st_q == SQ_IDLE);
  assign in_move  = (st_q == SQ_MOVE);
  assign in_fin   = (st_q == SQ_FIN);
  assign move_end = in_move && !sel_any;

  blkxfer_pick #(.NREG(NREG), .IDXW(IDXW)) u_pick (
    .pend (pend_q),
    .up   (am_up(mode_q)),
    .any  (sel_any),
    .idx  (sel_idx)
  );

  blkxfer_addr #(.XLEN(XLEN), .STEP(4)) u_addr (
    .start_mode (mode),
    .base       (base_val),
    .run_mode   (mode_q),
    .run_addr   (run_q),
    .start_addr (start_addr),
    .next_addr  (next_addr),
    .wb_addr    (wb_addr),
    .issue_addr (issue_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      pend_q <= '0;
      run_q  <= '0;
      bidx_q <= '0;
      mode_q <= '0;
      load_q <= 1'b0;
      wb_q   <= 1'b0;
      user_q <= 1'b0;
      pcl_q  <= 1'b0;
      bank_q <= 1'b0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (accept) begin
            pend_q <= list_in;
            run_q  <= start_addr;
            bidx_q <= bidx_in;
            mode_q <= mode;
            load_q <= is_load;
            wb_q   <= wback_en;
            user_q <= user_bank;
            pcl_q  <= is_load && list_in[NREG-1];
            bank_q <= user_bank;
            st_q   <= SQ_MOVE;
          end
        end
        SQ_MOVE: begin
          if (xfer_fire) begin
            pend_q[sel_idx] <= 1'b0;
            run_q           <= next_addr;
          end
          if (move_end) begin
            bank_q <= 1'b0;
            st_q   <= SQ_FIN;
          end
        end
        default: begin
          st_q <= SQ_IDLE;
        end
      endcase
    end
  end

  assign busy      = (st_q != SQ_IDLE);
  assign done      = in_fin;
  assign sys_bank  = bank_q;
  assign pc_reload = in_fin && pcl_q;

  assign mem_req   = in_move && sel_any;
  assign mem_we    = mem_req && !load_q;
  assign mem_addr  = issue_addr;
  assign mem_wdata = rf_rdata;
  assign xfer_fire = mem_req && mem_ack;

  assign rf_raddr  = sel_idx;
  assign rf_we     = (xfer_fire && load_q) || (in_fin && wb_q);
  assign rf_waddr  = in_fin ? bidx_q : sel_idx;
  assign rf_wdata  = in_fin ? wb_addr : mem_rdata;
endmodule

// File: rtl/blkxfer_chk.sv
module blkxfer_chk #(
  parameter int XLEN = 32,
  parameter int NREG = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [NREG-1:0] instr_list,
  input logic            mem_req,
  input logic            mem_ack,
  input logic [XLEN-1:0] mem_addr,
  input logic            sys_bank,
  input logic            pc_reload,
  input logic            rf_we,
  input logic            xfer_fire,
  input logic            user_q,
  input logic            wb_q,
  input logic            up_q
);
  localparam int CW = $clog2(NREG + 1);

  logic [CW-1:0]   exp_cnt, fire_cnt;
  logic [XLEN-1:0] last_addr;
  logic            has_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_cnt   <= '0;
      fire_cnt  <= '0;
      last_addr <= '0;
      has_last  <= 1'b0;
    end else if (start && !busy) begin
      exp_cnt  <= CW'($countones(instr_list));
      fire_cnt <= '0;
      has_last <= 1'b0;
    end else if (xfer_fire) begin
      fire_cnt  <= fire_cnt + CW'(1);
      last_addr <= mem_addr;
      has_last  <= 1'b1;
    end
  end

  a_r4_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_fire && has_last |->
      mem_addr == (up_q ? last_addr + XLEN'(4) : last_addr - XLEN'(4)));

  a_r3_count: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> fire_cnt == exp_cnt);

  a_r7_bank_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && user_q |-> sys_bank);

  a_r7_bank_restored: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !sys_bank);

  a_r8_reload_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    pc_reload |-> done);

  a_r6_wb_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done && wb_q |-> rf_we);

  a_r12_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
endmodule

bind blkxfer_seq blkxfer_chk #(.XLEN(XLEN), .NREG(NREG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .instr_list (instr[NREG-1:0]),
  .mem_req    (mem_req),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .sys_bank   (sys_bank),
  .pc_reload  (pc_reload),
  .rf_we      (rf_we),
  .xfer_fire  (xfer_fire),
  .user_q     (user_q),
  .wb_q       (wb_q),
  .up_q       (mode_q[0])
);

// File: tb/tb_blkxfer_seq.sv
module tb_blkxfer_seq;
  localparam logic [1:0] M_DA = 2'b00, M_IA = 2'b01, M_DB = 2'b10, M_IB = 2'b11;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, start, is_load, wback_en, user_bank;
  logic [31:0] instr, base_val;
  logic [1:0]  mode;
  logic        busy, done, sys_bank, pc_reload, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata;
  logic [3:0]  rf_raddr, rf_waddr;
  logic        rf_we;

  blkxfer_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .mode(mode),
    .is_load(is_load), .wback_en(wback_en), .user_bank(user_bank),
    .base_val(base_val), .busy(busy), .done(done), .sys_bank(sys_bank),
    .pc_reload(pc_reload), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  logic [31:0] rf  [16];
  logic [31:0] mem [256];
  logic [31:0] log_addr [32];
  logic [3:0]  log_reg  [32];
  logic        log_bank [32];
  int          log_n;
  int          wait_cfg, wcnt;
  int          n_chk = 0, n_bad = 0;

  assign rf_rdata = rf[rf_raddr];

  // Register file, memory and transfer log models
  always @(posedge clk) begin
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (mem_req && mem_ack && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (mem_req && mem_ack && log_n < 32) begin
      log_addr[log_n] <= mem_addr;
      log_reg[log_n]  <= mem_we ? rf_raddr : rf_waddr;
      log_bank[log_n] <= sys_bank;
      log_n           <= log_n + 1;
    end
  end

  // Memory responder with configurable wait cycles, driven at the falling edge
  always @(negedge clk) begin
    if (mem_req) begin
      if (wcnt >= wait_cfg) begin
        mem_ack   = 1'b1;
        mem_rdata = mem[mem_addr[9:2]];
        wcnt      = 0;
      end else begin
        mem_ack = 1'b0;
        wcnt    = wcnt + 1;
      end
    end else begin
      mem_ack = 1'b0;
      wcnt    = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nth_bit(input logic [15:0] list, input int r);
    int seen = 0;
    for (int b = 0; b < 16; b++) begin
      if (list[b]) begin
        if (seen == r) return b;
        seen++;
      end
    end
    return -1;
  endfunction

  task automatic launch(input logic [15:0] list, input logic [3:0] bidx,
                        input logic [1:0] md, input bit ld, input bit wb,
                        input bit usr);
    @(negedge clk);
    instr     = {12'h000, bidx, list};
    mode      = md;
    is_load   = ld;
    wback_en  = wb;
    user_bank = usr;
    base_val  = rf[bidx];
    log_n     = 0;
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
  endtask

  task automatic wait_done(output bit pcl, output bit bank);
    int guard = 0;
    while (done !== 1'b1 && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    pcl  = pc_reload;
    bank = sys_bank;
    @(negedge clk);
    chk(done == 1'b0, "R12 done width one cycle", {31'b0, done}, 32'h0);
  endtask

  // Checks order, register indices and addresses of the logged transfers.
  task automatic check_seq(input logic [15:0] list, input logic [1:0] md,
                           input logic [31:0] base);
    int n = $countones(list);
    logic [31:0] low;
    case (md)
      M_IA:    low = base;
      M_IB:    low = base + 32'd4;
      M_DA:    low = base - 32'(4 * (n - 1));
      default: low = base - 32'(4 * n);
    endcase
    chk(log_n == n, "R3 transfer count", 32'(log_n), 32'(n));
    if (log_n == n) begin
      for (int i = 0; i < n; i++) begin
        int r = md[0] ? i : n - 1 - i;
        logic [31:0] ea = (low + 32'(4 * r)) & ~32'h3;
        chk(log_reg[i] == 4'(nth_bit(list, r)), "R1/R3 register order",
            {28'b0, log_reg[i]}, 32'(nth_bit(list, r)));
        chk(log_addr[i] == ea, (i == 0) ? "R2 first address" : "R3 address step",
            log_addr[i], ea);
      end
    end
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R12 idle after reset", {31'b0, busy}, 0);
    chk(done == 1'b0, "R12 no done after reset", {31'b0, done}, 0);
    chk(mem_req == 1'b0, "R4 no request after reset", {31'b0, mem_req}, 0);
    chk(sys_bank == 1'b0, "R7 bank idle after reset", {31'b0, sys_bank}, 0);
    chk(pc_reload == 1'b0, "R8 reload idle after reset", {31'b0, pc_reload}, 0);
  endtask

  task automatic t_store_ia();
    bit pcl, bank;
    logic [31:0] v [16];
    wait_cfg = 0;
    rf[13] = 32'h100;
    for (int i = 0; i < 16; i++) v[i] = rf[i];
    launch(16'h00F0, 4'd13, M_IA, 0, 1, 0);
    wait_done(pcl, bank);
    check_seq(16'h00F0, M_IA, 32'h100);
    for (int k = 0; k < 4; k++)
      chk(mem[64 + k] == v[4 + k], "R5 store data", mem[64 + k], v[4 + k]);
    chk(rf[13] == 32'h110, "R6 R1 writeback inc-after", rf[13], 32'h110);
    chk(pcl == 1'b0, "R8 no reload on store", {31'b0, pcl}, 0);
  endtask

  task automatic t_load_db();
    bit pcl, bank;
    wait_cfg = 2;
    rf[2] = 32'h200;
    launch(16'h8005, 4'd2, M_DB, 1, 1, 0);
    wait_done(pcl, bank);
    check_seq(16'h8005, M_DB, 32'h200);
    chk(rf[0] == mem[125], "R5 load r0", rf[0], mem[125]);
    chk(rf[15] == mem[127], "R5 load r15", rf[15], mem[127]);
    chk(rf[2] == 32'h1F4, "R6 writeback overrides load", rf[2], 32'h1F4);
    chk(pcl == 1'b1, "R8 reload on top-register load", {31'b0, pcl}, 1);
  endtask

  task automatic t_store_da_nowb();
    bit pcl, bank;
    logic [31:0] v1, v11;
    wait_cfg = 1;
    rf[9] = 32'h300;
    v1 = rf[1]; v11 = rf[11];
    launch(16'h0A02, 4'd9, M_DA, 0, 0, 0);
    wait_done(pcl, bank);
    check_seq(16'h0A02, M_DA, 32'h300);
    chk(mem[190] == v1, "R5 store r1 dec-after", mem[190], v1);
    chk(mem[191] == 32'h300, "R5 store base r9", mem[191], 32'h300);
    chk(mem[192] == v11, "R5 store r11", mem[192], v11);
    chk(rf[9] == 32'h300, "R6 no writeback", rf[9], 32'h300);
  endtask

  task automatic t_store_ib();
    bit pcl, bank;
    logic [31:0] v0;
    wait_cfg = 0;
    rf[3] = 32'h40;
    v0 = rf[0];
    launch(16'h0009, 4'd3, M_IB, 0, 1, 0);
    wait_done(pcl, bank);
    check_seq(16'h0009, M_IB, 32'h40);
    chk(mem[17] == v0, "R5 store r0 inc-before", mem[17], v0);
    chk(mem[18] == 32'h40, "R6 original base stored", mem[18], 32'h40);
    chk(rf[3] == 32'h48, "R6 writeback inc-before", rf[3], 32'h48);
  endtask

  task automatic t_load_user();
    bit pcl, bank;
    wait_cfg = 1;
    rf[1] = 32'h80;
    launch(16'h0006, 4'd1, M_IA, 1, 0, 1);
    wait_done(pcl, bank);
    check_seq(16'h0006, M_IA, 32'h80);
    for (int i = 0; i < log_n; i++)
      chk(log_bank[i] == 1'b1, "R7 bank during transfer", {31'b0, log_bank[i]}, 1);
    chk(bank == 1'b0, "R7 bank restored at done", {31'b0, bank}, 0);
    chk(rf[1] == mem[32], "R5 load into base without writeback", rf[1], mem[32]);
    chk(pcl == 1'b0, "R8 no reload without bit 15", {31'b0, pcl}, 0);
  endtask

  task automatic t_empty();
    bit pcl, bank;
    wait_cfg = 0;
    rf[5] = 32'h120;
    launch(16'h0000, 4'd5, M_IB, 1, 1, 0);
    wait_done(pcl, bank);
    chk(log_n == 0, "R9 empty list no transfers", 32'(log_n), 0);
    chk(rf[5] == 32'h120, "R9 base unchanged", rf[5], 32'h120);
    chk(busy == 1'b0, "R9 completes", {31'b0, busy}, 0);
  endtask

  task automatic t_unaligned();
    bit pcl, bank;
    logic [31:0] v4, v5;
    wait_cfg = 0;
    rf[6] = 32'h103;
    v4 = rf[4]; v5 = rf[5];
    launch(16'h0030, 4'd6, M_IA, 0, 0, 0);
    wait_done(pcl, bank);
    check_seq(16'h0030, M_IA, 32'h103);
    chk(log_addr[0] == 32'h100, "R10 aligned first address", log_addr[0], 32'h100);
    chk(mem[64] == v4 && mem[65] == v5, "R10 aligned store data", mem[65], v5);
  endtask

  task automatic t_busy_start();
    bit pcl, bank;
    logic [31:0] m_before;
    wait_cfg = 3;
    rf[8]  = 32'h180;
    rf[10] = 32'h380;
    m_before = mem[224];
    launch(16'h0060, 4'd8, M_IA, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    instr    = {12'h000, 4'd10, 16'hFFFF};
    base_val = 32'h380;
    wback_en = 1'b1;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
    wait_done(pcl, bank);
    chk(log_n == 2, "R11 second start ignored count", 32'(log_n), 2);
    chk(rf[10] == 32'h380, "R11 ignored start no writeback", rf[10], 32'h380);
    chk(mem[224] == m_before, "R11 ignored start no store", mem[224], m_before);
    chk(busy == 1'b0, "R11 no restart after done", {31'b0, busy}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; instr = '0; mode = '0; is_load = 1'b0;
    wback_en = 1'b0; user_bank = 1'b0; base_val = '0;
    mem_ack = 1'b0; mem_rdata = '0; wait_cfg = 0; wcnt = 0; log_n = 0;
    for (int i = 0; i < 16; i++) rf[i] = 32'h5A00_0000 | (i * 32'h101);
    for (int i = 0; i < 256; i++) mem[i] = 32'hC000_0000 + i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_store_ia();
    t_load_db();
    t_store_da_nowb();
    t_store_ib();
    t_load_user();
    t_empty();
    t_unaligned();
    t_busy_start();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule